// File: doc/BRIEF.md
# Static-Order Branching Unit with Conflict-Directed Backjump

This unit picks the next variable to branch on for a hardware depth-first satisfiability search. Variables have a fixed order: index 0 first, index NV-1 last. Because every decision takes the lowest-indexed free variable, the assigned variables always form a prefix 0..depth-1. The surrounding pipeline pulses `step` when the latest assignment has been evaluated with no conflict. It pulses `conflict_valid` with a bit-vector of the variables that took part in a conflict.

Conflict vectors are OR-ed into a sticky pool. A priority encoder searches that pool for the latest-ordered variable whose second polarity has not yet been tried. Every assigned variable above that target is released, one per cycle and latest first. The target is then flipped. A variable that has already been tried both ways is never flipped again: it is released, so the search jumps further back. When no candidate remains, the problem is reported unsatisfiable. When a `step` arrives with all variables assigned, it is reported satisfiable. Each change is announced as a one-cycle pulse carrying index, value and a set/release flag.

Top module: `dcd_decider`

## Requirements
- R1: After reset, or in the cycle after `start`, the depth is 0, `ready` is 1, `sat` and `unsat` are 0, and no pulse is produced.
- R2: An accepted `step` with depth below NV produces, in the next cycle, one pulse with `asg_var` = depth, `asg_val` = FIRST_VAL (0 by default) and `asg_set` = 1. The depth then grows by one.
- R3: An accepted conflict ORs its vector into the pool. Bits at indices equal to or above the current depth are ignored.
- R4: The backjump target is the highest index in the pool whose tried flag is clear. It is flipped with a pulse carrying the opposite of its current value and `asg_set` = 1. Its tried flag is set, its pool bit is cleared, and the depth becomes target+1.
- R5: Before the flip, each assigned variable above the target is released with a pulse (`asg_set` = 0, `asg_val` = 0), in descending index order, one per cycle. The first pulse follows the conflict's edge by one cycle. Released variables lose their tried flag and pool bit.
- R6: `ready` is low from the edge that accepts a conflict until the flip pulse has been issued. While it is low, `step` and `conflict_valid` are ignored.
- R7: A conflict that leaves no untried candidate in the pool (including an empty pool) sets `unsat` in the next cycle and produces no pulse.
- R8: An accepted `step` with all NV variables assigned sets `sat` in the next cycle.
- R9: Once `sat` or `unsat` is set, it stays set and inputs other than `start` are ignored until `start`.
- R10: When `step` and `conflict_valid` arrive in the same cycle, only the conflict is acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears all search state and begins a new search |
| step | input | 1 | Latest assignment evaluated without conflict; branch further |
| conflict_valid | input | 1 | A conflict vector is present |
| conflict_vars | input | NV | One bit per variable involved in the conflict |
| ready | output | 1 | High when inputs are accepted |
| asg_valid | output | 1 | One-cycle pulse announcing a set or release |
| asg_var | output | IW | Index of the variable concerned |
| asg_val | output | 1 | Value assigned (0 on release) |
| asg_set | output | 1 | 1 = assignment, 0 = release |
| sat | output | 1 | Sticky: all variables assigned without conflict |
| unsat | output | 1 | Sticky: no flip candidate remained |

## Verification
A branching pulse is due one cycle after the edge that samples `step`. The `sat` and `unsat` flags are also due one cycle after the sampling edge. A backjump issues P pulses on the P edges that follow the conflict's edge, where P is the number of released variables plus one. `ready` is low for exactly those P cycles. The bench drives inputs and samples outputs on falling edges. A queue-based monitor matches each pulse against the predicted sequence, and the driver counts the cycles `ready` stays low and compares that count with P.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [1:0] {
    DS_SEARCH = 2'd0,
    DS_UNWIND = 2'd1,
    DS_DONE   = 2'd2
  } dstate_e;
endpackage

// File: rtl/dcd_msb.sv
module dcd_msb #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  // Highest set bit wins; the ascending scan lets later bits overwrite.
  function automatic logic [IW-1:0] top_index(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign idx   = top_index(vec);
  assign found = |vec;
endmodule

// File: rtl/dcd_varfile.sv
module dcd_varfile #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          merge_en,
  input  logic [W-1:0]  merge_vec,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_val,
  input  logic          wr_tried,
  input  logic          free_en,
  input  logic [IW-1:0] free_idx,
  output logic [W-1:0]  vals,
  output logic [W-1:0]  tried,
  output logic [W-1:0]  pool
);
  for (genvar g = 0; g < W; g++) begin : g_var
    logic v_q, t_q, p_q;
    logic hit_wr, hit_free;
    assign hit_wr   = wr_en   && (wr_idx   == IW'(g));
    assign hit_free = free_en && (free_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= 1'b0;
        p_q <= 1'b0;
      end else if (clr_all) begin
        v_q <= 1'b0;
        t_q <= 1'b0;
        p_q <= 1'b0;
      end else begin
        if (merge_en && merge_vec[g]) p_q <= 1'b1;
        if (hit_wr) begin
          v_q <= wr_val;
          t_q <= wr_tried;
          p_q <= 1'b0;
        end
        if (hit_free) begin
          v_q <= 1'b0;
          t_q <= 1'b0;
          p_q <= 1'b0;
        end
      end
    end

    assign vals[g]  = v_q;
    assign tried[g] = t_q;
    assign pool[g]  = p_q;
  end
endmodule

// File: rtl/dcd_decider.sv
module dcd_decider #(
  parameter int   NV        = 8,
  parameter logic FIRST_VAL = 1'b0,
  localparam int  IW        = (NV > 1) ? $clog2(NV) : 1,
  localparam int  LW        = $clog2(NV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic          conflict_valid,
  input  logic [NV-1:0] conflict_vars,
  output logic          ready,
  output logic          asg_valid,
  output logic [IW-1:0] asg_var,
  output logic          asg_val,
  output logic          asg_set,
  output logic          sat,
  output logic          unsat
);
  import dcd_pkg::*;

  // Bits strictly below the depth are the assigned prefix.
  function automatic logic [NV-1:0] prefix_mask(input logic [LW-1:0] depth);
    logic [NV-1:0] m;
    for (int i = 0; i < NV; i++) m[i] = (LW'(i) < depth);
    return m;
  endfunction

  dstate_e       st_q;
  logic [LW-1:0] lvl_q;
  logic [IW-1:0] cursor_q;
  logic [IW-1:0] tgt_q;

  logic [NV-1:0] vals_w, tried_w, pool_w;
  logic [NV-1:0] asg_mask_w, new_bits_w, cand_w;
  logic [IW-1:0] tgt_w;
  logic          cand_found_w;
  logic          all_set_w;
  logic          take_conf_w, take_step_w;
  logic          unwinding_w, flip_now_w;

  assign ready        = (st_q == DS_SEARCH);
  assign asg_mask_w   = prefix_mask(lvl_q);
  assign new_bits_w   = conflict_vars & asg_mask_w;
  assign cand_w       = (pool_w | new_bits_w) & ~tried_w & asg_mask_w;
  assign all_set_w    = (lvl_q == LW'(NV));
  assign take_conf_w  = ready && conflict_valid && !start;
  assign take_step_w  = ready && step && !conflict_valid && !start;
  assign unwinding_w  = (st_q == DS_UNWIND) && !start;
  assign flip_now_w   = unwinding_w && !(cursor_q > tgt_q);

  dcd_msb #(.W(NV), .IW(IW)) u_msb (
    .vec   (cand_w),
    .idx   (tgt_w),
    .found (cand_found_w)
  );

  logic          wr_en_w, wr_val_w, wr_tried_w;
  logic [IW-1:0] wr_idx_w;

  always_comb begin
    wr_en_w    = 1'b0;
    wr_idx_w   = '0;
    wr_val_w   = 1'b0;
    wr_tried_w = 1'b0;
    if (take_step_w && !all_set_w) begin
      wr_en_w  = 1'b1;
      wr_idx_w = lvl_q[IW-1:0];
      wr_val_w = FIRST_VAL;
    end else if (flip_now_w) begin
      wr_en_w    = 1'b1;
      wr_idx_w   = tgt_q;
      wr_val_w   = ~vals_w[tgt_q];
      wr_tried_w = 1'b1;
    end
  end

  dcd_varfile #(.W(NV), .IW(IW)) u_vars (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (start),
    .merge_en  (take_conf_w),
    .merge_vec (new_bits_w),
    .wr_en     (wr_en_w),
    .wr_idx    (wr_idx_w),
    .wr_val    (wr_val_w),
    .wr_tried  (wr_tried_w),
    .free_en   (unwinding_w && !flip_now_w),
    .free_idx  (cursor_q),
    .vals      (vals_w),
    .tried     (tried_w),
    .pool      (pool_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= DS_SEARCH;
      lvl_q     <= '0;
      cursor_q  <= '0;
      tgt_q     <= '0;
      asg_valid <= 1'b0;
      asg_var   <= '0;
      asg_val   <= 1'b0;
      asg_set   <= 1'b0;
      sat       <= 1'b0;
      unsat     <= 1'b0;
    end else if (start) begin
      st_q      <= DS_SEARCH;
      lvl_q     <= '0;
      asg_valid <= 1'b0;
      sat       <= 1'b0;
      unsat     <= 1'b0;
    end else begin
      asg_valid <= 1'b0;
      unique case (st_q)
        DS_SEARCH: begin
          if (take_conf_w) begin
            if (cand_found_w) begin
              st_q     <= DS_UNWIND;
              tgt_q    <= tgt_w;
              cursor_q <= IW'(lvl_q - LW'(1));
            end else begin
              unsat <= 1'b1;
              st_q  <= DS_DONE;
            end
          end else if (take_step_w) begin
            if (all_set_w) begin
              sat  <= 1'b1;
              st_q <= DS_DONE;
            end else begin
              asg_valid <= 1'b1;
              asg_var   <= lvl_q[IW-1:0];
              asg_val   <= FIRST_VAL;
              asg_set   <= 1'b1;
              lvl_q     <= lvl_q + LW'(1);
            end
          end
        end
        DS_UNWIND: begin
          asg_valid <= 1'b1;
          if (flip_now_w) begin
            asg_var <= tgt_q;
            asg_val <= ~vals_w[tgt_q];
            asg_set <= 1'b1;
            lvl_q   <= LW'(tgt_q) + LW'(1);
            st_q    <= DS_SEARCH;
          end else begin
            asg_var  <= cursor_q;
            asg_val  <= 1'b0;
            asg_set  <= 1'b0;
            lvl_q    <= LW'(cursor_q);
            cursor_q <= cursor_q - IW'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcd_chk.sv
module dcd_chk #(
  parameter int NV = 8,
  parameter int IW = 3,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ready,
  input logic          asg_valid,
  input logic [IW-1:0] asg_var,
  input logic          asg_set,
  input logic          sat,
  input logic          unsat,
  input logic [LW-1:0] lvl
);
  // R7
  sat_unsat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat && unsat));

  // R5
  release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && !asg_set) |-> !ready);

  // R5
  release_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && !asg_set && !start) |=> asg_valid);

  // R2
  set_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && asg_set) |-> (lvl == LW'(asg_var) + LW'(1)));

  // R5
  release_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && !asg_set) |-> (lvl == LW'(asg_var)));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !start) |=> sat);

  // R9
  unsat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unsat && !start) |=> unsat);

  // R7
  unsat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unsat) |-> !asg_valid);

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sat && !unsat && !asg_valid && ready && lvl == '0));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> (lvl == LW'(NV)));
endmodule

bind dcd_decider dcd_chk #(.NV(NV), .IW(IW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ready     (ready),
  .asg_valid (asg_valid),
  .asg_var   (asg_var),
  .asg_set   (asg_set),
  .sat       (sat),
  .unsat     (unsat),
  .lvl       (lvl_q)
);

// File: tb/sim_dcd_decider.sv
module sim_dcd_decider;
  localparam int NV = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, step = 1'b0, conflict_valid = 1'b0;
  logic [NV-1:0] conflict_vars = '0;
  logic          ready, asg_valid, asg_val, asg_set, sat, unsat;
  logic [IW-1:0] asg_var;

  always #2 clk = ~clk;

  dcd_decider #(.NV(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .conflict_valid(conflict_valid), .conflict_vars(conflict_vars),
    .ready(ready), .asg_valid(asg_valid), .asg_var(asg_var),
    .asg_val(asg_val), .asg_set(asg_set), .sat(sat), .unsat(unsat)
  );

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  bit finished = 0;

  // Reference model of the search state
  int m_lvl;
  bit m_val[NV], m_tried[NV], m_pool[NV];

  function automatic int code(int v, bit val, bit set);
    return v * 4 + (val ? 2 : 0) + (set ? 1 : 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_lvl = 0;
    for (int i = 0; i < NV; i++) begin
      m_val[i] = 0; m_tried[i] = 0; m_pool[i] = 0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: every pulse must match the next predicted item
  always @(negedge clk) begin
    if (rst_n && asg_valid) begin
      int got;
      got = code(int'(asg_var), asg_val, asg_set);
      if (exp_q.size() == 0) begin
        check(0, "R2/R4/R5/R6/R9 unexpected pulse", got, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(got == e, "R2/R4/R5 pulse", got, e);
      end
    end
  end

  task automatic do_start();
    start = 1; @(negedge clk); start = 0;
    model_clear();
    check(sat == 0 && unsat == 0, "R1 flags after start", {sat, unsat}, 0);
    check(ready == 1, "R1 ready after start", ready, 1);
    check(asg_valid == 0, "R1 no pulse after start", asg_valid, 0);
  endtask

  task automatic do_step();
    while (!ready) @(negedge clk);
    if (m_lvl < NV) begin
      exp_q.push_back(code(m_lvl, 1'b0, 1'b1));
      m_val[m_lvl] = 0; m_tried[m_lvl] = 0; m_pool[m_lvl] = 0;
      m_lvl++;
      step = 1; @(negedge clk); step = 0;
      check(sat == 0, "R2 no sat while branching", sat, 0);
    end else begin
      step = 1; @(negedge clk); step = 0;
      check(sat == 1, "R8 sat after full depth", sat, 1);
    end
  endtask

  // with_step drives step together with the conflict (R10);
  // poke_busy drives step while ready is low (R6)
  task automatic do_conflict(logic [NV-1:0] vec, bit with_step, bit poke_busy);
    int t, p, busy;
    t = -1;
    while (!ready) @(negedge clk);
    for (int i = 0; i < m_lvl; i++) if (vec[i]) m_pool[i] = 1;
    for (int i = 0; i < m_lvl; i++) if (m_pool[i] && !m_tried[i]) t = i;
    p = 0;
    if (t >= 0) begin
      for (int v = m_lvl - 1; v > t; v--) begin
        exp_q.push_back(code(v, 1'b0, 1'b0));
        m_val[v] = 0; m_tried[v] = 0; m_pool[v] = 0;
        p++;
      end
      m_val[t] = !m_val[t]; m_tried[t] = 1; m_pool[t] = 0;
      exp_q.push_back(code(t, m_val[t], 1'b1));
      m_lvl = t + 1;
      p++;
    end
    conflict_valid = 1; conflict_vars = vec; step = with_step;
    @(negedge clk);
    conflict_valid = 0; conflict_vars = '0; step = 0;
    if (t < 0) begin
      check(unsat == 1, "R7 unsat raised", unsat, 1);
      check(asg_valid == 0, "R7 no pulse on unsat", asg_valid, 0);
    end else begin
      check(asg_valid == 0, "R5 first pulse one cycle later", asg_valid, 0);
      busy = 0;
      while (!ready && busy < 64) begin
        busy++;
        if (poke_busy) step = 1;
        @(negedge clk);
        step = 0;
      end
      check(busy == p, "R6 busy cycles", busy, p);
    end
  endtask

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1, "R1 ready after reset", ready, 1);
    check(sat == 0 && unsat == 0, "R1 flags after reset", {sat, unsat}, 0);
    check(asg_valid == 0, "R1 no pulse after reset", asg_valid, 0);

    repeat (3) do_step();                 // R2: vars 0,1,2
    do_conflict(8'h05, 0, 0);             // R4: flip var 2
    repeat (2) do_step();                 // vars 3,4
    do_conflict(8'h10, 0, 0);             // R4: flip var 4
    do_conflict(8'h90, 0, 0);             // R3 bit7 ignored, R5 release 4..1, flip 0
    do_step();                            // var 1
    do_conflict(8'h02, 1, 0);             // R10: conflict beats step
    repeat (2) do_step();                 // vars 2,3
    do_conflict(8'h04, 0, 1);             // R6: step ignored while busy
    while (m_lvl < NV) do_step();
    do_step();                            // R8
    // R9: inputs ignored after sat
    step = 1; @(negedge clk); step = 0;
    conflict_valid = 1; conflict_vars = 8'hFF; @(negedge clk);
    conflict_valid = 0; conflict_vars = '0;
    check(sat == 1 && unsat == 0, "R9 sat holds", {sat, unsat}, 2);
    check(ready == 0, "R9 not ready when done", ready, 0);

    do_start();
    do_conflict(8'h00, 0, 0);             // R7: empty pool
    do_start();
    do_step();
    do_conflict(8'h01, 0, 0);             // flip var 0
    do_conflict(8'h01, 0, 0);             // R7: first var tried both ways
    step = 1; @(negedge clk); step = 0;
    check(unsat == 1, "R9 unsat holds", unsat, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2/R5 all predicted pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule